// File: doc/BRIEF.md
# MDIO Management Master

This block is a hardware master for the Ethernet MII management serial link. It derives the management clock from the system clock, shifts out the frame that addresses a PHY register, and either drives sixteen data bits (write) or releases the shared data line and captures sixteen bits from the PHY (read). The data line is presented as three separate signals: an output value, an output enable and an input. An external tri-state buffer with a pull-up joins them to the pad.

A client starts a transaction with a single-cycle request. The request carries a read flag, a 5-bit PHY address, a 5-bit register address and a 16-bit write value. The block raises `busy` until it returns a one-cycle `done` pulse. For a read, the captured word then appears on `rd_data`. If the PHY does not pull the second turnaround bit low, the block keeps clocking for a further 32 cycles with the line released, so that a confused PHY can return to a known state. It then finishes with `err` set.

Every frame starts with a preamble that is one bit longer than the minimum. This makes the block tolerant of PHYs that need a full preamble after power-up or after a protocol error.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever no transaction is running, `mdc` is low, `mdio_oe` is low and `busy` is low.
- R2: While a transaction runs, `mdc` is high for HALF_DIV system clocks and low for HALF_DIV system clocks, so one full period is 2*HALF_DIV clocks. The default of 40 gives 2.5 MHz from a 200 MHz clock.
- R3: Each frame opens with 33 consecutive '1' bits driven with `mdio_oe` high.
- R4: The preamble is followed by the start pattern 0 then 1. Next comes the opcode, which is 1 then 0 for a read and 0 then 1 for a write.
- R5: The PHY address is sent next, MSB first. The register address follows it, also MSB first.
- R6: A write drives the turnaround pattern 1 then 0 and then the 16 write bits, MSB first. `mdio_oe` stays high through the last data bit and is low once `done` pulses. A write takes 65 `mdc` periods.
- R7: A read drops `mdio_oe` from the first turnaround bit (frame bit 47, counted from 0) to the end. It samples 16 data bits on rising `mdc` edges, MSB first, and presents them on `rd_data` with `done`. A successful read takes 65 `mdc` periods and clears `err`.
- R8: If the second turnaround bit of a read is sampled as '1', the block runs 32 further `mdc` periods with `mdio_oe` low, for 81 periods in total. It then pulses `done` with `err` high, and `rd_data` keeps its previous value.
- R9: `mdio_out` changes only when `mdc` falls (or when a request is accepted), so it is stable while `mdc` is high. Input bits are taken on rising `mdc` edges.
- R10: A request is accepted only when `busy` is low, and `busy` is high from the cycle after acceptance until the `done` cycle. A request raised while busy is ignored: it does not alter the frame in flight and starts no later transaction.
- R11: `done` is high for exactly one cycle. `rd_data` and `err` hold their values until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a transaction (sampled while idle) |
| req_read | input | 1 | 1 = read, 0 = write |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Data for a write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last read saw no turnaround from the PHY |
| rd_data | output | 16 | Data captured by the last successful read |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Value driven on the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| mdio_in | input | 1 | Sampled level of the data line |

## Verification
The hardest path to reach is the turnaround failure. It happens only on a read, and it depends on the level the line floats to in the one `mdc` period after the master has released it. The bench wraps the block in a line model made of a pull-up and a behavioural PHY that drives on falling `mdc` edges. Turning the PHY's response off makes the pull-up win the second turnaround bit. The bench then counts the flush periods, checks that the line stays released throughout, and confirms that the earlier read value survives. A following good read must clear `err` again.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PRE_LEN    = 33;
    localparam int DATA_W     = 16;
    localparam int FRAME_W    = 2 + 2 + 5 + 5 + 2 + DATA_W;
    localparam int TOTAL_BITS = PRE_LEN + FRAME_W;
    localparam int TA_FIRST   = PRE_LEN + 14;
    localparam int TA_SECOND  = TA_FIRST + 1;
    localparam int DATA_FIRST = TA_SECOND + 1;
    localparam int FLUSH_LEN  = 32;
    localparam int IDX_W      = $clog2(TOTAL_BITS + 1);
    localparam int FL_W       = $clog2(FLUSH_LEN + 1);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAME = 2'd1,
        ST_FLUSH = 2'd2
    } mstate_e;

    typedef struct packed {
        logic              is_read;
        logic [4:0]        phy;
        logic [4:0]        regad;
        logic [DATA_W-1:0] wdata;
    } mreq_t;

    // Bits that follow the preamble, first bit on the wire in the MSB.
    function automatic logic [FRAME_W-1:0] build_frame(mreq_t r);
        logic [1:0] op;
        logic [1:0] ta;
        logic [DATA_W-1:0] d;
        op = r.is_read ? 2'b10 : 2'b01;
        ta = r.is_read ? 2'b11 : 2'b10;
        d  = r.is_read ? '1 : r.wdata;
        return {2'b01, op, r.phy, r.regad, ta, d};
    endfunction

    function automatic logic frame_bit(logic [FRAME_W-1:0] f, logic [IDX_W-1:0] idx);
        logic [4:0] pos;
        if (int'(idx) < PRE_LEN) begin
            return 1'b1;
        end
        pos = 5'(FRAME_W - 1 - (int'(idx) - PRE_LEN));
        return f[pos];
    endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int HALF_DIV = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt_q;
    logic          mdc_q;
    logic          term;

    assign term = run && (cnt_q == CW'(HALF_DIV - 1));
    assign rise = term && !mdc_q;
    assign fall = term && mdc_q;
    assign mdc  = mdc_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (term) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: the clock level moves only on a divider tick
    a_r2_mdc_steady: assert property (@(posedge clk) disable iff (rst)
        !(rise || fall) |=> $stable(mdc));

    // R2: a rising tick always leaves the clock high
    a_r2_rise_sets: assert property (@(posedge clk) disable iff (rst)
        rise |=> mdc);

endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            word <= '0;
        end else if (shift_en) begin
            word <= {word[W-2:0], din};
        end
    end
endmodule

// File: rtl/mdio_fsm.sv
module mdio_fsm
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  mreq_t             req,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_in,
    input  logic [DATA_W-1:0] rx_word,
    output logic              run,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic              rx_clear,
    output logic              rx_shift
);
    mstate_e            state_q;
    logic [IDX_W-1:0]   idx_q;
    logic [FL_W-1:0]    flush_q;
    logic [FRAME_W-1:0] frame_q;
    logic               rd_q;
    logic               ta_bad_q;
    logic               last_bit;
    logic               ta_check;

    assign busy     = (state_q != ST_IDLE);
    assign run      = busy;
    assign last_bit = (idx_q == IDX_W'(TOTAL_BITS - 1));
    assign ta_check = rd_q && (idx_q == IDX_W'(TA_SECOND));
    assign mdio_oe  = (state_q == ST_FRAME) && (!rd_q || (idx_q < IDX_W'(TA_FIRST)));
    assign mdio_out = (state_q == ST_FRAME) ? frame_bit(frame_q, idx_q) : 1'b0;
    assign rx_clear = (state_q == ST_IDLE) && req_valid;
    assign rx_shift = (state_q == ST_FRAME) && rd_q && rise && (idx_q >= IDX_W'(DATA_FIRST));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            idx_q    <= '0;
            flush_q  <= '0;
            frame_q  <= '0;
            rd_q     <= 1'b0;
            ta_bad_q <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
            rd_data  <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        frame_q  <= build_frame(req);
                        rd_q     <= req.is_read;
                        idx_q    <= '0;
                        ta_bad_q <= 1'b0;
                        err      <= 1'b0;
                        state_q  <= ST_FRAME;
                    end
                end
                ST_FRAME: begin
                    if (rise && ta_check && mdio_in) begin
                        ta_bad_q <= 1'b1;
                    end
                    if (fall) begin
                        if (last_bit) begin
                            state_q <= ST_IDLE;
                            done    <= 1'b1;
                            if (rd_q) begin
                                rd_data <= rx_word;
                            end
                        end else if (ta_check && ta_bad_q) begin
                            state_q <= ST_FLUSH;
                            flush_q <= '0;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ST_FLUSH: begin
                    if (fall) begin
                        if (flush_q == FL_W'(FLUSH_LEN - 1)) begin
                            state_q <= ST_IDLE;
                            done    <= 1'b1;
                            err     <= 1'b1;
                        end else begin
                            flush_q <= flush_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R11: completion is a single-cycle pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: busy has dropped by the time done is seen
    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R11: result held while idle with no new request
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !req_valid) |=> ($stable(rd_data) && $stable(err)));

    // R10: a request seen while busy leaves the frame in flight untouched
    a_r10_ignore_busy: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(frame_q));

    // R3: preamble bits are driven ones
    a_r3_preamble_ones: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FRAME && idx_q < IDX_W'(PRE_LEN)) |-> (mdio_oe && mdio_out));

    // R8: the flush only follows a failed turnaround
    a_r8_flush_cause: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FRAME && fall && ta_check && ta_bad_q) |=> (state_q == ST_FLUSH && !mdio_oe));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 40
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_read,
    input  logic [4:0]  req_phy,
    input  logic [4:0]  req_reg,
    input  logic [15:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [15:0] rd_data,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    mreq_t             req_s;
    logic              run_w;
    logic              rise_w;
    logic              fall_w;
    logic              rx_clear_w;
    logic              rx_shift_w;
    logic [DATA_W-1:0] rx_word_w;

    assign req_s = '{is_read: req_read, phy: req_phy, regad: req_reg, wdata: req_wdata};

    mdio_clkdiv #(.HALF_DIV(HALF_DIV)) clkdiv_i (
        .clk  (clk),
        .rst  (rst),
        .run  (run_w),
        .mdc  (mdc),
        .rise (rise_w),
        .fall (fall_w)
    );

    mdio_rx_shift #(.W(DATA_W)) rx_i (
        .clk      (clk),
        .rst      (rst),
        .clear    (rx_clear_w),
        .shift_en (rx_shift_w),
        .din      (mdio_in),
        .word     (rx_word_w)
    );

    mdio_fsm fsm_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req       (req_s),
        .rise      (rise_w),
        .fall      (fall_w),
        .mdio_in   (mdio_in),
        .rx_word   (rx_word_w),
        .run       (run_w),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .rd_data   (rd_data),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe),
        .rx_clear  (rx_clear_w),
        .rx_shift  (rx_shift_w)
    );

    // R1: no clock and no drive while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdio_oe));

    // R9: the driven value moves only on a falling clock tick
    a_r9_out_on_fall: assert property (@(posedge clk) disable iff (rst)
        (busy && !fall_w) |=> $stable(mdio_out));

endmodule

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_read = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, err, mdc, mdio_out, mdio_oe;
    logic [15:0] rd_data;

    logic        phy_drv = 1'b0;
    logic        phy_val = 1'b1;
    logic        phy_on = 1'b0;
    logic [15:0] phy_word = '0;
    wire         mdio_line = mdio_oe ? mdio_out : (phy_drv ? phy_val : 1'b1);

    always #2.5 clk = ~clk;

    mdio_master #(.HALF_DIV(HALF)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_read(req_read),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .err(err), .rd_data(rd_data),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_line)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int rise_cnt = 0;
    int fall0 = 0;
    int viol = 0;
    int done_w = 0;
    logic last_out = 1'b0;
    logic bits [0:127];
    logic oes  [0:127];
    int   rtim [0:127];

    always @(negedge clk) cyc++;

    always @(posedge mdc) begin
        if (rise_cnt < 128) begin
            bits[rise_cnt] = mdio_line;
            oes[rise_cnt]  = mdio_oe;
            rtim[rise_cnt] = cyc;
        end
        last_out = mdio_out;
        rise_cnt++;
    end

    // Behavioural PHY: changes its output after the falling clock edge
    always @(negedge mdc) begin
        if (rise_cnt == 1) fall0 = cyc;
        if (phy_on && rise_cnt == 48) begin
            phy_drv = 1'b1; phy_val = 1'b0;
        end else if (phy_on && rise_cnt >= 49 && rise_cnt <= 64) begin
            phy_drv = 1'b1; phy_val = phy_word[64 - rise_cnt];
        end else begin
            phy_drv = 1'b0; phy_val = 1'b1;
        end
    end

    always @(negedge clk) begin
        if (mdc && (mdio_out !== last_out)) viol++;
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (cyc > 150000) begin
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
                finish_run();
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_frame(logic rd, logic [4:0] p, logic [4:0] r, logic [15:0] d);
        return {2'b01, (rd ? 2'b10 : 2'b01), p, r, 2'b10, d};
    endfunction

    function automatic logic [31:0] cap_frame();
        logic [31:0] v = '0;
        for (int k = 0; k < 32; k++) v[31-k] = bits[33+k];
        return v;
    endfunction

    task automatic fire(input logic rd, input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_read = rd; req_phy = p; req_reg = r; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        done_w = 0;
        while (done) begin
            done_w++;
            @(negedge clk);
        end
    endtask

    task automatic start_txn(input logic rd, input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
        rise_cnt = 0; viol = 0;
        fire(rd, p, r, d);
    endtask

    task automatic test_reset();
        chk("R1 mdc after reset", 32'(mdc), 0);
        chk("R1 oe after reset", 32'(mdio_oe), 0);
        chk("R1 busy after reset", 32'(busy), 0);
        chk("R11 done after reset", 32'(done), 0);
    endtask

    task automatic test_write(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
        int ones = 0;
        int oe_ok = 0;
        logic [31:0] f;
        start_txn(1'b0, p, r, d);
        chk("R10 busy after accept", 32'(busy), 1);
        wait_done();
        f = cap_frame();
        for (int k = 0; k < 33; k++) if (bits[k]) ones++;
        for (int k = 0; k < 65; k++) if (oes[k]) oe_ok++;
        chk("R3 preamble ones", ones, 33);
        chk("R4 start+write opcode", 32'(f[31:28]), 32'h5);
        chk("R5 phy/reg address", 32'(f[27:18]), 32'({p, r}));
        chk("R6 turnaround+data", 32'(f[17:0]), 32'({2'b10, d}));
        chk("R6 oe high all bits", oe_ok, 65);
        chk("R6 period count", rise_cnt, 65);
        chk("R6 released after write", 32'(mdio_oe), 0);
        chk("R1 mdc low when idle", 32'(mdc), 0);
        chk("R2 period", rtim[1] - rtim[0], 2 * HALF);
        chk("R2 high time", fall0 - rtim[0], HALF);
        chk("R9 out stable while mdc high", viol, 0);
        chk("R11 done width", done_w, 1);
    endtask

    task automatic test_read(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
        logic [31:0] f;
        int rel = 0;
        phy_on = 1'b1; phy_word = d;
        start_txn(1'b1, p, r, 16'h0);
        wait_done();
        phy_on = 1'b0;
        f = cap_frame();
        for (int k = 47; k < 65; k++) if (!oes[k]) rel++;
        chk("R4 start+read opcode", 32'(f[31:28]), 32'h6);
        chk("R5 read address", 32'(f[27:18]), 32'({p, r}));
        chk("R7 oe before turnaround", 32'(oes[46]), 1);
        chk("R7 released from turnaround", rel, 18);
        chk("R7 read data", 32'(rd_data), 32'(d));
        chk("R7 no error", 32'(err), 0);
        chk("R7 period count", rise_cnt, 65);
        chk("R9 out stable while mdc high", viol, 0);
        repeat (50) @(negedge clk);
        chk("R11 read data held", 32'(rd_data), 32'(d));
    endtask

    task automatic test_fault(input logic [15:0] prev);
        int rel = 0;
        phy_on = 1'b0;
        start_txn(1'b1, 5'h07, 5'h02, 16'h0);
        wait_done();
        for (int k = 47; k < 81; k++) if (!oes[k]) rel++;
        chk("R8 error flag", 32'(err), 1);
        chk("R8 flush period count", rise_cnt, 81);
        chk("R8 line released in flush", rel, 34);
        chk("R8 read data kept", 32'(rd_data), 32'(prev));
        chk("R11 done width on error", done_w, 1);
        repeat (40) @(negedge clk);
        chk("R11 error held", 32'(err), 1);
    endtask

    task automatic test_busy_ignore();
        logic [31:0] f;
        int after;
        rise_cnt = 0; viol = 0;
        fire(1'b0, 5'h11, 5'h05, 16'h1234);
        repeat (30) @(negedge clk);
        req_valid = 1'b1; req_read = 1'b1; req_phy = 5'h0E; req_reg = 5'h1B;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        f = cap_frame();
        chk("R10 frame unchanged by busy request", f, exp_frame(1'b0, 5'h11, 5'h05, 16'h1234));
        after = rise_cnt;
        repeat (200) @(negedge clk);
        chk("R10 no later transaction", rise_cnt, after);
        chk("R10 idle after ignored request", 32'(busy), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_write(5'h13, 5'h0A, 16'hA55A);
        test_write(5'h00, 5'h1F, 16'h0001);
        test_read(5'h01, 5'h1F, 16'hC3A7);
        test_read(5'h1E, 5'h10, 16'h8001);
        test_fault(16'h8001);
        test_read(5'h02, 5'h03, 16'h5AF0);
        test_busy_ignore();
        finish_run();
    end
endmodule